// File: doc/BRIEF.md
# Quadrature Switching Demodulator Sequencer

This block steers four external analog switches that together form a coarse two-bit bipolar multiplying DAC. The DAC is used to synchronously demodulate a signal whose frequency is one eighth of the clock rate. For example, an 80 MHz clock demodulates a 10 MHz signal.

A free-running phase counter walks through the eight steps of one signal period. For each step, a lookup produces a stepped sine-like weight of +2, +1, -1 or -2, and the weight is encoded onto the four switch lines. A quadrature select input picks between the in-phase weighting and a copy shifted by 90 degrees, so the external DAC output carries either the in-phase or the quadrature component. The four switch lines come from one common register, so they always change together on a single clock edge.

Top module: `quad_demod_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the phase counter goes to step 0 and all four switch lines are driven low at that edge. The first non-zero pattern appears one edge after `rst` is sampled low, and it belongs to step 0.
- R2: Outside reset, the phase counter advances by one step on every clock edge and wraps from step 7 to step 0, so the output pattern repeats every 8 cycles.
- R3: With `quad_sel` low, the weight at steps 0 to 7 is +1, +2, +2, +1, -1, -2, -2, -1. Each weight is shown on the outputs one edge after its step.
- R4: With `quad_sel` high, the weight at step k equals the in-phase weight at step (k+2) mod 8, which is a 90 degree advance.
- R5: `pos_msb`/`pos_lsb` are never asserted in the same cycle as `neg_msb`/`neg_lsb`.
- R6: A change of `quad_sel` takes effect at the next edge. It does not disturb the phase counter.
- R7: The weights are encoded one-hot on the outputs: +2 is `pos_msb` alone, +1 is `pos_lsb` alone, -1 is `neg_lsb` alone and -2 is `neg_msb` alone. Outside reset, exactly one line is high, and all lines update on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, eight times the demodulated signal frequency |
| rst | input | 1 | Synchronous reset, active high |
| quad_sel | input | 1 | 0: in-phase weighting, 1: quadrature weighting |
| pos_msb | output | 1 | Closes the weight-2 switch to the positive reference |
| pos_lsb | output | 1 | Closes the weight-1 switch to the positive reference |
| neg_msb | output | 1 | Closes the weight-2 switch to the negative reference |
| neg_lsb | output | 1 | Closes the weight-1 switch to the negative reference |

## Verification
The sequencer is first run through uninterrupted in-phase periods, which confirms the step order, the encoding and the 8-cycle repetition. It is then run in quadrature mode, which tells a correct two-step advance apart from a wrong shift direction or amount. Toggling `quad_sel` every few cycles shows whether a mode change restarts the phase or only swaps the table. Finally, a reset is issued mid-period and released with quadrature already selected, which checks the exact latency and the step-0 starting point.

// File: rtl/quad_demod_seq.sv
module quad_demod_seq #(
  parameter int PHASE_W = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic quad_sel,
  output logic pos_msb,
  output logic pos_lsb,
  output logic neg_msb,
  output logic neg_lsb
);

  localparam int NSTEP  = 1 << PHASE_W;
  localparam int HALF   = NSTEP / 2;
  localparam int QSHIFT = NSTEP / 4;

  logic [PHASE_W-1:0] phase_q;
  logic [PHASE_W-1:0] look_idx;
  logic [3:0]         lines_d, lines_q;

  function automatic logic [3:0] code_at(input logic [PHASE_W-1:0] idx);
    int  p;
    logic big;
    p   = int'(idx) % HALF;
    big = (p >= NSTEP / 8) && (p < (3 * NSTEP) / 8);
    if (int'(idx) < HALF) return big ? 4'b1000 : 4'b0100;
    else                  return big ? 4'b0010 : 4'b0001;
  endfunction

  assign look_idx = phase_q + (quad_sel ? PHASE_W'(QSHIFT) : '0);
  assign lines_d  = code_at(look_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      lines_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
      lines_q <= lines_d;
    end
  end

  assign {pos_msb, pos_lsb, neg_msb, neg_lsb} = lines_q;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (lines_q == '0 && phase_q == '0));

  assert_phase_step_R2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> phase_q == PHASE_W'($past(phase_q) + 1'b1));

  assert_rail_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    !((pos_msb || pos_lsb) && (neg_msb || neg_lsb)));

  assert_mode_keeps_phase_R6: assert property (@(posedge clk) disable iff (rst)
    (!$stable(quad_sel) && !$past(rst)) |=> phase_q == PHASE_W'($past(phase_q) + 1'b1));

  assert_single_line_R7: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $countones({pos_msb, pos_lsb, neg_msb, neg_lsb}) == 1);

endmodule

// File: tb/quad_demod_seq_tb.sv
module quad_demod_seq_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic quad_sel = 1'b0;
  logic pos_msb, pos_lsb, neg_msb, neg_lsb;

  quad_demod_seq u_dut (
    .clk(clk), .rst(rst), .quad_sel(quad_sel),
    .pos_msb(pos_msb), .pos_lsb(pos_lsb), .neg_msb(neg_msb), .neg_lsb(neg_lsb)
  );

  always #5 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  int ref_phase = 0;
  logic [3:0] exp_lines = 4'b0000;
  string cur_req = "R1";
  logic [3:0] hist[$];
  int wt[8] = '{1, 2, 2, 1, -1, -2, -2, -1};

  function automatic logic [3:0] enc(input int w);
    case (w)
      2:  return 4'b1000;
      1:  return 4'b0100;
      -1: return 4'b0001;
      -2: return 4'b0010;
      default: return 4'b0000;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      ref_phase = 0;
      exp_lines = 4'b0000;
    end else begin
      exp_lines = enc(wt[(ref_phase + (quad_sel ? 2 : 0)) % 8]);
      ref_phase = (ref_phase + 1) % 8;
    end
  end

  always @(negedge clk) begin
    logic [3:0] got;
    got = {pos_msb, pos_lsb, neg_msb, neg_lsb};
    cycles++;
    compared++;
    if (got !== exp_lines) begin
      mismatched++;
      $display("FAIL %s: lines=%b expected=%b", cur_req, got, exp_lines);
    end
    compared++;
    if ((got[3] | got[2]) & (got[1] | got[0])) begin
      mismatched++;
      $display("FAIL R5: lines=%b expected no pos/neg overlap", got);
    end
    if (exp_lines != 4'b0000) begin
      compared++;
      if ($countones(got) != 1) begin
        mismatched++;
        $display("FAIL R7: lines=%b expected one line high", got);
      end
    end
    if (cur_req == "R2" && hist.size() == 8) begin
      compared++;
      if (got !== hist[0]) begin
        mismatched++;
        $display("FAIL R2: lines=%b expected repeat %b", got, hist[0]);
      end
    end
    hist.push_back(got);
    if (hist.size() > 8) void'(hist.pop_front());
    if (cycles > 5000) begin
      mismatched++;
      $display("FAIL watchdog: cycles=%0d expected <= 5000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic step(input int n, input logic r, input logic q, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      rst = r;
      quad_sel = q;
      cur_req = req;
    end
  endtask

  initial begin
    step(4, 1'b1, 1'b0, "R1");
    step(8, 1'b0, 1'b0, "R3");
    step(16, 1'b0, 1'b0, "R2");
    step(16, 1'b0, 1'b1, "R4");
    for (int k = 0; k < 8; k++) step(3, 1'b0, k[0], "R6");
    step(1, 1'b0, 1'b1, "R6");
    step(1, 1'b0, 1'b0, "R6");
    step(5, 1'b0, 1'b0, "R3");
    step(2, 1'b1, 1'b1, "R1");
    step(10, 1'b0, 1'b1, "R1");
    @(negedge clk);
    #2;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule